// File: doc/BRIEF.md
# Interleaved Multi-Chip Banked Memory

This block is a word-addressable, single-port synchronous memory assembled from an array of small, narrow RAM chips rather than one flat array. The chips are grouped into banks. Every bank holds the same number of words as one chip, and each bank stripes a full word across several chip lanes. An incoming address is split into a bank number and an in-bank offset. Only the addressed bank is enabled. All chips of that bank see the same offset, and each one stores its own slice of the word.

A compile-time mode decides which address bits choose the bank. In low-order mode the least-significant bits choose the bank, so consecutive addresses fall in consecutive banks. In high-order mode the most-significant bits choose the bank, so each bank holds one contiguous block of addresses. A read returns its word one clock after the request, marked by a one-cycle valid strobe. A one-hot bank-enable output shows which bank serves the current access.

Top module: `ilv_banked_mem`

## Requirements
- R1: While reset is held and after it is released with no request, `rd_valid` is 0 and `bank_en` is all zeros.
- R2: In low-order mode the bank number is the low log2(DEPTH/CHIP_DEPTH) address bits and the offset is the remaining upper bits, so address a is served by bank a mod NB (with 64 words and 16-word chips: bank = addr[1:0], offset = addr[5:2]).
- R3: In high-order mode the bank number is the top log2(DEPTH/CHIP_DEPTH) address bits, so addresses 0 to CHIP_DEPTH-1 are all served by bank 0 and address a by bank a / CHIP_DEPTH.
- R4: `bank_en` has bit i set for bank i. It carries exactly one set bit in each cycle where `req` is 1, and it is all zeros when `req` is 0.
- R5: A read request (`req`=1, `we`=0) raises `rd_valid` for exactly the next cycle, with `rd_data` holding the word last written to that address.
- R6: A write (`req`=1, `we`=1) raises no `rd_valid` and changes only the addressed word. Every other address reads back its earlier value.
- R7: A word is split over WORD_W/CHIP_W chips of CHIP_W bits at one shared offset. Chip lane j holds bits [j*CHIP_W +: CHIP_W], and every bit of the word round-trips.
- R8: With 8 banks over 64 words in low-order mode, address 14 is served by bank 6 (offset 1).
- R9: Elaboration fails if DEPTH/CHIP_DEPTH is not a power of two of at least 2, or if WORD_W is not a multiple of CHIP_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | log2(DEPTH) | Word address |
| wdata | input | WORD_W | Write data |
| rd_data | output | WORD_W | Read data, valid when rd_valid is 1 |
| rd_valid | output | 1 | One-cycle strobe, one clock after a read request |
| bank_en | output | DEPTH/CHIP_DEPTH | One-hot enable of the bank serving the current access |

## Verification
The bank enable is combinational, so the bench checks it a short delay after it drives the request at the falling edge, in the same cycle. Read data and the valid strobe come from registers. The bench checks them at the next falling edge, one rising edge after the request, and checks one edge later that the strobe has dropped. The same stimulus drives a low-order, a high-order and an 8-bank low-order instance together. Each of the three is compared with a flat reference array that the bench updates at every write.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;
    typedef enum logic {
        ILV_LOW  = 1'b0,
        ILV_HIGH = 1'b1
    } ilv_mode_e;
endpackage

// File: rtl/ilv_addr_split.sv
module ilv_addr_split
    import ilv_mem_pkg::*;
#(
    parameter ilv_mode_e MODE = ILV_LOW,
    parameter int AW = 6,
    parameter int KW = 2,
    localparam int OW = AW - KW
) (
    input  logic [AW-1:0] addr,
    output logic [KW-1:0] bank,
    output logic [OW-1:0] off
);
    generate
        if (MODE == ILV_LOW) begin : g_low
            // R2: bank from the low bits
            assign bank = addr[KW-1:0];
            assign off  = addr[AW-1:KW];
        end else begin : g_high
            // R3: bank from the high bits
            assign bank = addr[AW-1:OW];
            assign off  = addr[OW-1:0];
        end
    endgenerate
endmodule

// File: rtl/ilv_chip_ram.sv
module ilv_chip_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int OW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             we,
    input  logic [OW-1:0]    off,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];
    logic [WIDTH-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (en && !we) rdata_d = cells[off];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    always_ff @(posedge clk) begin
        if (en && we) cells[off] <= wdata;
    end

    assign rdata = rdata_q;

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || we) |=> $stable(rdata));
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int CHIP_DEPTH = 16,
    parameter int CHIP_W = 8,
    parameter int WORD_W = 16,
    localparam int OW = $clog2(CHIP_DEPTH),
    localparam int LANES = WORD_W / CHIP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [OW-1:0]     off,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    // R7: each lane chip stores one CHIP_W slice at the shared offset
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        ilv_chip_ram #(.DEPTH(CHIP_DEPTH), .WIDTH(CHIP_W)) u_chip (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .we    (we),
            .off   (off),
            .wdata (wdata[j*CHIP_W +: CHIP_W]),
            .rdata (rdata[j*CHIP_W +: CHIP_W])
        );
    end
endmodule

// File: rtl/ilv_banked_mem.sv
module ilv_banked_mem
    import ilv_mem_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WORD_W = 16,
    parameter int CHIP_DEPTH = 16,
    parameter int CHIP_W = 8,
    parameter ilv_mode_e MODE = ILV_LOW,
    localparam int NB = DEPTH / CHIP_DEPTH,
    localparam int AW = $clog2(DEPTH),
    localparam int KW = (NB > 1) ? $clog2(NB) : 1,
    localparam int OW = $clog2(CHIP_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [NB-1:0]     bank_en
);
    // R9: reject illegal geometry at elaboration
    if (NB < 2 || (NB & (NB - 1)) != 0 || (DEPTH % CHIP_DEPTH) != 0 ||
        (WORD_W % CHIP_W) != 0 || CHIP_DEPTH < 2) begin : g_bad_geom
        $error("ilv_banked_mem: illegal bank or lane geometry");
    end

    typedef struct packed {
        logic          rd_valid;
        logic [KW-1:0] rd_bank;
    } state_t;

    state_t st_d, st_q;
    logic [KW-1:0] bank;
    logic [OW-1:0] off;
    logic [NB-1:0][WORD_W-1:0] bank_rdata;

    ilv_addr_split #(.MODE(MODE), .AW(AW), .KW(KW)) u_split (
        .addr (addr),
        .bank (bank),
        .off  (off)
    );

    always_comb begin
        bank_en = '0;
        if (req) bank_en[bank] = 1'b1;
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        ilv_bank #(.CHIP_DEPTH(CHIP_DEPTH), .CHIP_W(CHIP_W), .WORD_W(WORD_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bank_en[b]),
            .we    (we),
            .off   (off),
            .wdata (wdata),
            .rdata (bank_rdata[b])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = req && !we;
        if (req && !we) st_d.rd_bank = bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NB; b++) begin
            if (st_q.rd_bank == KW'(b)) rd_data = bank_rdata[b];
        end
    end

    assign rd_valid = st_q.rd_valid;

    // R4
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $countones(bank_en) == 1);
    // R4
    idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> bank_en == '0);
    // R5
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rd_valid);
    // R6
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we) |=> !rd_valid);
    // R5
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req && !we));
endmodule

// File: tb/ilv_banked_mem_bench.sv
module ilv_banked_mem_bench;
    import ilv_mem_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;

    logic [15:0] rd_lo, rd_hi, rd_e8;
    logic        v_lo, v_hi, v_e8;
    logic [3:0]  be_lo, be_hi;
    logic [7:0]  be_e8;

    logic [15:0] ref_mem [64];
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ilv_banked_mem #(.MODE(ILV_LOW)) u_ilv_banked_mem (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rd_data(rd_lo), .rd_valid(v_lo), .bank_en(be_lo));

    ilv_banked_mem #(.MODE(ILV_HIGH)) u_ilv_banked_mem_hi (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rd_data(rd_hi), .rd_valid(v_hi), .bank_en(be_hi));

    ilv_banked_mem #(.CHIP_DEPTH(8), .MODE(ILV_LOW)) u_ilv_banked_mem_e8 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rd_data(rd_e8), .rd_valid(v_e8), .bank_en(be_e8));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access; checks bank decode in-cycle, strobe and data one edge later
    task automatic access(input logic w, input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        #1;
        chk("R2 low bank", 32'(be_lo), 32'(4'b1 << a[1:0]));
        chk("R3 high bank", 32'(be_hi), 32'(4'b1 << a[5:4]));
        chk("R4 e8 one-hot", 32'(be_e8), 32'(8'b1 << a[2:0]));
        if (w) ref_mem[a] = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        #1;
        chk(w ? "R6 low no strobe" : "R5 low strobe", 32'(v_lo), 32'(!w));
        chk(w ? "R6 high no strobe" : "R5 high strobe", 32'(v_hi), 32'(!w));
        chk(w ? "R6 e8 no strobe" : "R5 e8 strobe", 32'(v_e8), 32'(!w));
        if (!w) begin
            chk("R5 low data", 32'(rd_lo), 32'(ref_mem[a]));
            chk("R5 high data", 32'(rd_hi), 32'(ref_mem[a]));
            chk("R5 e8 data", 32'(rd_e8), 32'(ref_mem[a]));
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 valid in reset", 32'({v_lo, v_hi, v_e8}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 valid after reset", 32'({v_lo, v_hi, v_e8}), 32'd0);
        chk("R1 bank_en idle", 32'({be_lo, be_hi, be_e8}), 32'd0);
    endtask

    task automatic t_fill;
        for (int i = 0; i < 64; i++) access(1'b1, 6'(i), 16'(i * 16'h0101) ^ 16'h5A3C);
        for (int i = 0; i < 64; i++) access(1'b0, 6'(i), 16'h0);
    endtask

    task automatic t_lanes;
        // R7: distinct byte patterns and all-ones, all-zeros per lane
        access(1'b1, 6'd9, 16'hA55A); access(1'b0, 6'd9, 16'h0);
        access(1'b1, 6'd9, 16'hFF00); access(1'b0, 6'd9, 16'h0);
        access(1'b1, 6'd9, 16'h00FF); access(1'b0, 6'd9, 16'h0);
        access(1'b1, 6'd63, 16'hFFFF); access(1'b0, 6'd63, 16'h0);
        chk("R7 lane split", 32'(rd_lo), 32'h0000FFFF);
    endtask

    task automatic t_low_consecutive;
        // R2: consecutive addresses walk banks 0,1,2,3
        for (int i = 20; i < 24; i++) begin
            @(negedge clk);
            req = 1'b1; we = 1'b0; addr = 6'(i);
            #1;
            chk("R2 consecutive", 32'(be_lo), 32'(4'b1 << (i % 4)));
            @(negedge clk); req = 1'b0;
        end
    endtask

    task automatic t_high_block;
        // R3: the first 16 addresses all in bank 0
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            req = 1'b1; we = 1'b0; addr = 6'(i);
            #1;
            chk("R3 first block bank0", 32'(be_hi), 32'd1);
            @(negedge clk); req = 1'b0;
        end
    endtask

    task automatic t_eight_way;
        // R8: address 14 -> bank 6
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 6'd14;
        #1;
        chk("R8 addr14 bank6", 32'(be_e8), 32'h40);
        @(negedge clk); req = 1'b0;
        access(1'b1, 6'd14, 16'hC3E1);
        access(1'b0, 6'd6, 16'h0);
        access(1'b0, 6'd14, 16'h0);
    endtask

    task automatic t_idle;
        // R4: no request -> no bank enabled, no strobe
        @(negedge clk);
        req = 1'b0; addr = 6'd33;
        #1;
        chk("R4 idle bank_en", 32'({be_lo, be_hi, be_e8}), 32'd0);
        @(negedge clk); #1;
        chk("R4 idle strobe", 32'({v_lo, v_hi, v_e8}), 32'd0);
    endtask

    task automatic t_random;
        // R6: random writes touch only their own word
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            access(r[31], r[5:0], r[23:8]);
        end
        for (int i = 0; i < 64; i++) access(1'b0, 6'(i), 16'h0);
    endtask

    initial begin
        void'($urandom(32'd7));
        t_reset;
        t_fill;
        t_lanes;
        t_low_consecutive;
        t_high_block;
        t_eight_way;
        t_idle;
        t_random;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule